// File: doc/BRIEF.md
# Lockable Four-Way Data Cache

This block is a 4-way set-associative data cache placed between a 32-bit processor load/store port and a memory port that moves 16-byte lines. For every set and way it keeps a tag, a valid bit and a dirty bit, and it stores one 128-bit line. It finds hits and refills whole lines on a miss. Replacement follows a true least-recently-used order for each set. Two static inputs change how it behaves. `cfg_wt` selects write-through instead of write-back. `cfg_lock` keeps the upper two ways (2 and 3) out of replacement.

The processor side uses a request/ready handshake. `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` stay steady until `cpu_ready` is high at a rising clock edge. A single-cycle pulse on `inv_req` starts a global invalidate, and the port stalls while it runs. The memory side raises `mem_req` and holds it, together with a steady address, until `mem_ack` arrives. `mem_wmask` carries one enable bit per 32-bit word of the line.

The controller has five states, declared in this order in the package. The names use the enum spelling:

- `ST_IDLE` serves hits.
- `ST_EVICT` writes back a dirty victim line.
- `ST_FILL` reads the missing line.
- `ST_WTHRU` performs a write-through store.
- `ST_FLUSH` sweeps the sets to invalidate them.

The transitions are:

- `ST_IDLE`→`ST_FLUSH` on `inv_req`.
- `ST_IDLE`→`ST_WTHRU` on a store while write-through is selected.
- `ST_IDLE`→`ST_EVICT` on a miss whose victim is valid and dirty.
- `ST_IDLE`→`ST_FILL` on any other miss.
- `ST_EVICT`→`ST_FILL` on acknowledge.
- `ST_FILL`→`ST_IDLE` on acknowledge. The held request then hits.
- `ST_WTHRU`→`ST_IDLE` on acknowledge.
- `ST_FLUSH`→`ST_IDLE` after the last set.

Top module: `dcache_lockable`

## Requirements
- R1: A load whose line is present returns the addressed word. The word index is address bits [3:2]. `cpu_ready` is high in the same cycle the request is presented, and no memory transfer takes place.
- R2: A load miss issues one memory read at the line address {tag = addr[31:11], index = addr[10:4], 4'b0000}. It returns the correct word once the refill completes, and the access is a hit afterwards.
- R3: Without lock, a miss fills the lowest-numbered invalid way first. When all four ways are valid it replaces the least recently accessed way. Every served access makes its way the most recent.
- R4: With `cfg_lock` high, a miss only replaces way 0 or way 1, choosing the older of the two. Lines in ways 2 and 3 still hit, and those hits update the recency order.
- R5: In write-back mode, a store hit writes only the cache word, completes in the cycle it is presented, makes no memory transfer, and marks the line dirty.
- R6: In write-back mode, a store miss allocates: it refills the line, then writes the word into it without a memory write.
- R7: A dirty victim is written to memory as a whole line, with all `mem_wmask` bits set, at its own line address. This happens before the refill read begins.
- R8: In write-through mode, a store makes one memory write of the word at its line address. `mem_wmask` bit k is set for word k (bytes 4k..4k+3) only. On a hit the cached word is updated as well. `cpu_ready` rises with `mem_ack`, and lines never become dirty.
- R9: In write-through mode, a store miss does not allocate a line, so a later load of that address misses.
- R10: `inv_req` clears every valid and dirty bit in one pass of 128 cycles, one set per cycle. `cpu_ready` and `mem_req` stay low during the pass.
- R11: Once `mem_req` is raised, it stays high with an unchanged `mem_addr` until `mem_ack` is seen.
- R12: After reset every line is invalid, and `cpu_ready` and `mem_req` are low.
- R13: No two valid ways of one set ever hold the same tag, so at most one way hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wt | input | 1 | 1 = write-through, 0 = write-back |
| cfg_lock | input | 1 | 1 = ways 2 and 3 excluded from replacement |
| inv_req | input | 1 | Start global invalidate |
| cpu_req | input | 1 | Access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access completes at this edge |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Write line |
| mem_wmask | output | 4 | Per-word write enables |
| mem_rdata | input | 128 | Read line, valid with `mem_ack` |
| mem_ack | input | 1 | Memory transfer done |

## Verification
The assertions assume four things about the inputs:

- The processor keeps its request fields steady until `cpu_ready`.
- `inv_req` arrives only while no access is mid-refill.
- `cfg_wt` and `cfg_lock` do not change while an access is pending.
- `mem_ack` is only raised in answer to `mem_req`.

The stimulus meets these conditions as follows. The access task holds every field until it sees `cpu_ready`. The configuration inputs are changed only between accesses. `inv_req` is pulsed while the port is idle. The memory model answers a request after a fixed latency and drops its acknowledge after one cycle.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU,
        ST_FLUSH
    } dc_state_e;
endpackage

// File: rtl/dcache_tag_match.sv
module dcache_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 21,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]       valid,
    input  logic [WAYS*TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]      tag,
    output logic [WAYS-1:0]       match,
    output logic                  hit,
    output logic [WAY_W-1:0]      way
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w*TAG_W +: TAG_W] == tag);
    end

    always_comb begin
        way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) way = WAY_W'(w);
        end
        hit = |match;
    end
endmodule

// File: rtl/dcache_victim.sv
module dcache_victim #(
    parameter int WAYS   = 4,
    parameter int WAY_W  = 2,
    parameter int LOCKED = 2
) (
    input  logic [WAYS-1:0]       valid,
    input  logic [WAYS*WAY_W-1:0] ranks,
    input  logic                  lock,
    output logic [WAY_W-1:0]      victim
);
    int         lim;
    logic       found;
    logic [WAY_W-1:0] best;

    always_comb begin
        lim    = lock ? (WAYS - LOCKED) : WAYS;
        victim = '0;
        found  = 1'b0;
        best   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && (w < lim) && !valid[w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if ((w < lim) && (ranks[w*WAY_W +: WAY_W] >= best)) begin
                    best   = ranks[w*WAY_W +: WAY_W];
                    victim = WAY_W'(w);
                end
            end
        end
    end
endmodule

// File: rtl/dcache_lru_next.sv
module dcache_lru_next #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS*WAY_W-1:0] rank_in,
    input  logic [WAY_W-1:0]      use_way,
    output logic [WAYS*WAY_W-1:0] rank_out
);
    logic [WAY_W-1:0] used_rank;

    assign used_rank = rank_in[use_way*WAY_W +: WAY_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_age
        always_comb begin
            if (WAY_W'(w) == use_way)
                rank_out[w*WAY_W +: WAY_W] = '0;
            else if (rank_in[w*WAY_W +: WAY_W] < used_rank)
                rank_out[w*WAY_W +: WAY_W] = rank_in[w*WAY_W +: WAY_W] + 1'b1;
            else
                rank_out[w*WAY_W +: WAY_W] = rank_in[w*WAY_W +: WAY_W];
        end
    end
endmodule

// File: rtl/dcache_lockable.sv
module dcache_lockable
    import dcache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int WAYS       = 4,
    parameter int SETS       = 128,
    parameter int LINE_BYTES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_wt,
    input  logic                         cfg_lock,
    input  logic                         inv_req,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [ADDR_W-1:0]            cpu_addr,
    input  logic [DATA_W-1:0]            cpu_wdata,
    output logic [DATA_W-1:0]            cpu_rdata,
    output logic                         cpu_ready,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [LINE_BYTES*8-1:0]      mem_wdata,
    output logic [LINE_BYTES*8/DATA_W-1:0] mem_wmask,
    input  logic [LINE_BYTES*8-1:0]      mem_rdata,
    input  logic                         mem_ack
);
    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int IDX_W    = $clog2(SETS);
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W   = LINE_BYTES * 8;
    localparam int WPL      = LINE_W / DATA_W;
    localparam int WSEL_W   = $clog2(WPL);
    localparam int WORD_OFF = $clog2(DATA_W / 8);
    localparam int WAY_W    = $clog2(WAYS);
    localparam int LOCKED   = WAYS / 2;

    dc_state_e state_q, state_d;

    logic [WAYS-1:0]       valid_q [SETS];
    logic [WAYS-1:0]       dirty_q [SETS];
    logic [WAYS*WAY_W-1:0] rank_q  [SETS];
    logic [TAG_W-1:0]      tag_q   [WAYS][SETS];
    logic [LINE_W-1:0]     data_q  [WAYS][SETS];
    logic [WAY_W-1:0]      vic_q;
    logic [IDX_W-1:0]      flush_q;

    logic [TAG_W-1:0]      req_tag;
    logic [IDX_W-1:0]      idx;
    logic [WSEL_W-1:0]     wsel;
    logic [WORD_OFF-1:0]   addr_lo_unused;
    logic [WAYS-1:0]       valid_v, dirty_v, match_v;
    logic [WAYS*TAG_W-1:0] tags_v;
    logic [WAYS*WAY_W-1:0] ranks_v, ranks_n;
    logic                  hit;
    logic [WAY_W-1:0]      hit_way, vic_way;
    logic                  serve, fill_done;

    assign req_tag        = cpu_addr[ADDR_W-1 -: TAG_W];
    assign idx            = cpu_addr[OFF_W +: IDX_W];
    assign wsel           = cpu_addr[WORD_OFF +: WSEL_W];
    assign addr_lo_unused = cpu_addr[WORD_OFF-1:0];

    always_comb begin
        valid_v = valid_q[idx];
        dirty_v = dirty_q[idx];
        ranks_v = rank_q[idx];
        for (int w = 0; w < WAYS; w++) tags_v[w*TAG_W +: TAG_W] = tag_q[w][idx];
    end

    dcache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .valid(valid_v), .tags(tags_v), .tag(req_tag),
        .match(match_v), .hit(hit), .way(hit_way)
    );

    dcache_victim #(.WAYS(WAYS), .WAY_W(WAY_W), .LOCKED(LOCKED)) u_victim (
        .valid(valid_v), .ranks(ranks_v), .lock(cfg_lock), .victim(vic_way)
    );

    dcache_lru_next #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lru (
        .rank_in(ranks_v), .use_way(hit_way), .rank_out(ranks_n)
    );

    assign cpu_rdata = data_q[hit_way][idx][wsel*DATA_W +: DATA_W];
    assign serve     = cpu_ready && hit;
    assign fill_done = (state_q == ST_FILL) && mem_ack;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_wmask = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (inv_req)                           state_d = ST_FLUSH;
                else if (cpu_req) begin
                    if (cpu_we && cfg_wt)              state_d = ST_WTHRU;
                    else if (hit)                      cpu_ready = 1'b1;
                    else if (valid_v[vic_way] && dirty_v[vic_way]) state_d = ST_EVICT;
                    else                               state_d = ST_FILL;
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {tag_q[vic_q][idx], idx, {OFF_W{1'b0}}};
                mem_wdata = data_q[vic_q][idx];
                mem_wmask = '1;
                if (mem_ack) state_d = ST_FILL;
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {req_tag, idx, {OFF_W{1'b0}}};
                if (mem_ack) state_d = ST_IDLE;
            end
            ST_WTHRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {req_tag, idx, {OFF_W{1'b0}}};
                mem_wdata = {WPL{cpu_wdata}};
                mem_wmask = WPL'(1) << wsel;
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_FLUSH: begin
                if (flush_q == IDX_W'(SETS - 1)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Control state: valid, dirty, recency, victim, sweep counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vic_q   <= '0;
            flush_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) rank_q[s][w*WAY_W +: WAY_W] <= WAY_W'(w);
            end
        end else begin
            if (state_q == ST_IDLE) vic_q <= vic_way;
            if (serve) begin
                rank_q[idx] <= ranks_n;
                if (cpu_we && !cfg_wt) dirty_q[idx][hit_way] <= 1'b1;
            end
            if (fill_done) begin
                valid_q[idx][vic_q] <= 1'b1;
                dirty_q[idx][vic_q] <= 1'b0;
            end
            if (state_q == ST_FLUSH) begin
                valid_q[flush_q] <= '0;
                dirty_q[flush_q] <= '0;
                flush_q <= (flush_q == IDX_W'(SETS - 1)) ? '0 : flush_q + 1'b1;
            end
        end
    end

    // Line storage and tags
    always_ff @(posedge clk) begin
        if (fill_done) begin
            data_q[vic_q][idx] <= mem_rdata;
            tag_q[vic_q][idx]  <= req_tag;
        end else if (serve && cpu_we) begin
            data_q[hit_way][idx][wsel*DATA_W +: DATA_W] <= cpu_wdata;
        end
    end

    // R13
    hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_v));
    // R4
    lock_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && !inv_req && !hit && cfg_lock && !(cpu_we && cfg_wt))
        |=> (vic_q < WAY_W'(WAYS - LOCKED)));
    // R8
    wt_no_local_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_ready && cpu_we) |-> !cfg_wt);
    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    // R7
    evict_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVICT && mem_ack) |=> (state_q == ST_FILL && !mem_we));
    // R10
    flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |-> (!cpu_ready && !mem_req));
    // R1
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);
endmodule

// File: tb/dcache_lockable_tb_top.sv
module dcache_lockable_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam int SETS       = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wt = 1'b0, cfg_lock = 1'b0, inv_req = 1'b0;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [3:0]   mem_wmask;
    logic [127:0] mem_rdata = '0;
    logic         mem_ack = 1'b0;

    int checks = 0, errors = 0;
    int nrd = 0, nwr = 0, stamp = 0, rd_stamp = 0, wr_stamp = 0, hold_err = 0, lat = 0;
    logic [31:0] last_ra, last_wa;
    logic [127:0] last_wd;
    logic [3:0]  last_wm;
    logic        pv_req = 1'b0, pv_ack = 1'b0;
    logic [31:0] pv_addr = '0;
    logic [31:0] over_m [int unsigned];
    logic [31:0] gold_m [int unsigned];

    always #(CLK_PERIOD/2) clk = ~clk;

    dcache_lockable dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wt(cfg_wt), .cfg_lock(cfg_lock), .inv_req(inv_req),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wmask(mem_wmask), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [31:0] mword(input logic [31:0] a);
        if (over_m.exists(a)) return over_m[a];
        return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
    endfunction

    function automatic logic [31:0] expect_rd(input logic [31:0] a);
        if (gold_m.exists(a)) return gold_m[a];
        return mword(a);
    endfunction

    function automatic logic [31:0] mk(input int t, input int s, input int w);
        return (32'(t) << 11) | (32'(s) << 4) | (32'(w) << 2);
    endfunction

    // memory model and hold monitor (R11)
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0; lat = 0; pv_req = 1'b0; pv_ack = 1'b0;
        end else begin
            if (pv_req && !pv_ack && (!mem_req || mem_addr != pv_addr)) hold_err++;
            pv_req  = mem_req;
            pv_addr = mem_addr;
            if (mem_ack) begin
                mem_ack = 1'b0; lat = 0;
            end else if (mem_req) begin
                lat++;
                if (lat >= LAT) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        for (int k = 0; k < 4; k++)
                            if (mem_wmask[k]) over_m[mem_addr + 32'(4*k)] = mem_wdata[32*k +: 32];
                        nwr++; last_wa = mem_addr; last_wd = mem_wdata; last_wm = mem_wmask;
                        stamp++; wr_stamp = stamp;
                    end else begin
                        for (int k = 0; k < 4; k++) mem_rdata[32*k +: 32] = mword(mem_addr + 32'(4*k));
                        nrd++; last_ra = mem_addr; stamp++; rd_stamp = stamp;
                    end
                end
            end
            pv_ack = mem_ack;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                          output int cyc, output logic [31:0] rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        cyc = 0;
        while (!cpu_ready && cyc < 2000) begin
            @(negedge clk); #1; cyc++;
        end
        if (cyc >= 2000) chk(1'b0, "watchdog-access", 0, 1);
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        if (we) gold_m[a] = wd;
    endtask

    task automatic rd_chk(input logic [31:0] a, input logic want_hit, input string req);
        int c, r0, w0;
        logic [31:0] d;
        r0 = nrd; w0 = nwr;
        access(1'b0, a, 0, c, d);
        chk(d == expect_rd(a), req, d, expect_rd(a));
        chk((c == 0) == want_hit, {req, " hit/miss"}, c, want_hit ? 0 : 1);
        if (want_hit) chk(nrd == r0 && nwr == w0, {req, " no mem"}, nrd - r0 + nwr - w0, 0);
    endtask

    initial begin
        int c, r0, w0;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        #1;
        // R12 reset state
        chk(!cpu_ready && !mem_req, "R12", {cpu_ready, mem_req}, 0);
        rst_n = 1'b1;

        // R12/R2 first load misses; line address
        r0 = nrd;
        access(1'b0, mk(3, 9, 2), 0, c, d);
        chk(c > 0 && nrd == r0 + 1, "R12 R2 miss", c, 1);
        chk(last_ra == mk(3, 9, 0), "R2 line addr", last_ra, mk(3, 9, 0));
        chk(d == expect_rd(mk(3, 9, 2)), "R2 data", d, expect_rd(mk(3, 9, 2)));
        rd_chk(mk(3, 9, 1), 1'b1, "R1");

        // R3 LRU, set 1
        for (int t = 0; t < 4; t++) rd_chk(mk(t, 1, 0), 1'b0, "R3 fill");
        for (int t = 0; t < 4; t++) rd_chk(mk(t, 1, 3), 1'b1, "R3 resident");
        rd_chk(mk(4, 1, 0), 1'b0, "R3 new");
        rd_chk(mk(0, 1, 0), 1'b0, "R3 oldest evicted");
        rd_chk(mk(2, 1, 0), 1'b1, "R3 kept");
        rd_chk(mk(3, 1, 0), 1'b1, "R3 kept");

        // R4 lock, set 2
        for (int t = 0; t < 4; t++) rd_chk(mk(t, 2, 0), 1'b0, "R4 fill");
        cfg_lock = 1'b1;
        rd_chk(mk(0, 2, 1), 1'b1, "R4 hit");
        rd_chk(mk(1, 2, 1), 1'b1, "R4 hit");
        rd_chk(mk(4, 2, 0), 1'b0, "R4 new");
        rd_chk(mk(2, 2, 0), 1'b1, "R4 locked way kept");
        rd_chk(mk(3, 2, 0), 1'b1, "R4 locked way kept");
        rd_chk(mk(1, 2, 0), 1'b1, "R4 unlocked younger kept");
        rd_chk(mk(4, 2, 0), 1'b1, "R4 new kept");
        rd_chk(mk(0, 2, 0), 1'b0, "R4 way0 evicted");
        rd_chk(mk(4, 2, 2), 1'b1, "R4 way1 older replaced");
        cfg_lock = 1'b0;

        // R5 R6 R7 write-back, set 5
        r0 = nrd; w0 = nwr;
        access(1'b1, mk(16, 5, 1), 32'hCAFE_0001, c, d);
        chk(c > 0 && nrd == r0 + 1 && nwr == w0, "R6 allocate", nwr - w0, 0);
        rd_chk(mk(16, 5, 1), 1'b1, "R6 R5 readback");
        w0 = nwr;
        access(1'b1, mk(16, 5, 1), 32'hCAFE_0002, c, d);
        chk(c == 0 && nwr == w0, "R5 store hit", c, 0);
        for (int t = 17; t < 20; t++) rd_chk(mk(t, 5, 0), 1'b0, "R7 fill");
        r0 = nrd; w0 = nwr;
        rd_chk(mk(20, 5, 0), 1'b0, "R7 evict");
        chk(nwr == w0 + 1 && nrd == r0 + 1, "R7 one write one read", nwr - w0, 1);
        chk(last_wa == mk(16, 5, 0), "R7 victim addr", last_wa, mk(16, 5, 0));
        chk(last_wm == 4'hF, "R7 full mask", last_wm, 4'hF);
        chk(last_wd[63:32] == 32'hCAFE_0002, "R7 dirty word", last_wd[63:32], 32'hCAFE_0002);
        chk(wr_stamp < rd_stamp, "R7 write before read", wr_stamp, rd_stamp);
        rd_chk(mk(16, 5, 1), 1'b0, "R7 reload");

        // R8 R9 write-through, set 6
        cfg_wt = 1'b1;
        rd_chk(mk(32, 6, 0), 1'b0, "R8 fill");
        r0 = nrd; w0 = nwr;
        access(1'b1, mk(32, 6, 2), 32'h0BAD_F00D, c, d);
        chk(nwr == w0 + 1 && nrd == r0 && c > 0, "R8 one write", nwr - w0, 1);
        chk(last_wm == 4'b0100, "R8 mask", last_wm, 4'b0100);
        chk(last_wa == mk(32, 6, 0), "R8 addr", last_wa, mk(32, 6, 0));
        chk(last_wd[95:64] == 32'h0BAD_F00D, "R8 data", last_wd[95:64], 32'h0BAD_F00D);
        rd_chk(mk(32, 6, 2), 1'b1, "R8 cache updated");
        r0 = nrd;
        access(1'b1, mk(33, 6, 3), 32'h1357_9BDF, c, d);
        chk(nrd == r0 && last_wm == 4'b1000, "R9 no allocate", last_wm, 4'b1000);
        rd_chk(mk(33, 6, 3), 1'b0, "R9 miss after store");
        for (int t = 34; t < 36; t++) rd_chk(mk(t, 6, 0), 1'b0, "R8 fill");
        w0 = nwr;
        rd_chk(mk(36, 6, 0), 1'b0, "R8 clean evict");
        chk(nwr == w0, "R8 never dirty", nwr - w0, 0);
        cfg_wt = 1'b0;

        // R10 invalidate
        rd_chk(mk(3, 9, 2), 1'b1, "R10 before");
        @(negedge clk); inv_req = 1'b1;
        @(negedge clk); inv_req = 1'b0;
        r0 = nrd;
        access(1'b0, mk(3, 9, 2), 0, c, d);
        chk(c >= SETS - 1 && nrd == r0 + 1, "R10 stall and miss", c, SETS);
        chk(d == expect_rd(mk(3, 9, 2)), "R10 data", d, expect_rd(mk(3, 9, 2)));
        rd_chk(mk(36, 6, 0), 1'b0, "R10 other set cleared");

        // R1 R2 R13 sweep over all sets, write-back
        for (int p = 0; p < 3; p++) begin
            for (int s = 0; s < SETS; s++) begin
                if (p == 1 && s % 2 == 0)
                    access(1'b1, mk(64 + (s + p) % 6, s, (s + p) % 4), 32'(s * 977 + p), c, d);
                else begin
                    access(1'b0, mk(64 + (s + p) % 6, s, (s + p) % 4), 0, c, d);
                    chk(d == expect_rd(mk(64 + (s + p) % 6, s, (s + p) % 4)), "R13 R1 sweep",
                        d, expect_rd(mk(64 + (s + p) % 6, s, (s + p) % 4)));
                end
            end
        end
        for (int s = 0; s < SETS; s += 2)
            rd_chk(mk(64 + (s + 1) % 6, s, (s + 1) % 4), 1'b1, "R5 R13 sweep readback");

        chk(hold_err == 0, "R11 hold", hold_err, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule